// File: doc/BRIEF.md
# Sample Input Queue with Access Stall

This block is an eight-deep, 32-bit queue that sits between up to eight serial audio input channels and a processor core. Channels offer samples through a request vector. At most one sample enters the queue per cycle. The core drains the queue, or pushes words into it, through a single register-style port. That port has a combinational ready line, so it can hold the bus master until the access can finish.

A programmable level raises an interrupt request while the queue holds more entries than that level. A control bit chooses how accesses that cannot proceed are handled:

- **Stalling:** a read of an empty queue, or a write to a full one, waits until it can complete.
- **Non-stalling:** such an access completes at once. A read returns zero and a write is thrown away.

A sample that a channel offers into a full queue in non-stalling mode is dropped and sets a sticky overflow flag. A write-one clear input resets that flag. Turning the enable bit off flushes the queue. While the block is disabled, channel samples are refused. A DMA-select bit is passed through as an output for the DMA logic outside the block.

Top module: `sif_infifo`

## Requirements
- R1: After synchronous reset, fill_cnt is 0, irq is 0, ovf_flag is 0, and no ready or acknowledge is raised while no request is present.
- R2: Words leave the queue in the order they entered it, and fill_cnt shows the number of stored words in the cycle after each push or pop, up to 8.
- R3: irq is 1 exactly while fill_cnt is strictly greater than cfg_thresh. With 8 entries stored, a level of 8 gives 0 and a level of 7 gives 1.
- R4: With cfg_nostall=0, a core read (core_req=1, core_we=0) of an empty queue keeps core_rdy at 0. It completes with the first stored word in the cycle after a word arrives.
- R5: With cfg_nostall=0, a core write (core_req=1, core_we=1) to a full queue keeps core_rdy at 0 and stores nothing. Once a word has been read out, the write completes.
- R6: With cfg_nostall=1, a core read of an empty queue completes at once with core_rdata=0. A core write to a full queue completes at once, and the word is discarded.
- R7: With the queue full, a channel request is held (chan_ack=0) when cfg_nostall=0. When cfg_nostall=1 it is acknowledged, its sample is dropped and ovf_flag is 1 from the next cycle on.
- R8: A cycle with cfg_ovf_clr=1 clears ovf_flag for the next cycle. If a drop happens in the same cycle, the flag stays set.
- R9: In the cycle where cfg_enable falls from 1 to 0, core_rdy is 0 and the queue is emptied: fill_cnt is 0 on the next cycle.
- R10: While cfg_enable is 0, no channel request is acknowledged and nothing from the channels is stored.
- R11: One word enters per cycle. A completing core write wins over every channel, and among channels the lowest index wins. chan_ack is one-hot or zero, and bit i acknowledges channel i.
- R12: dma_en follows cfg_dma_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_req | input | 8 | Per-channel sample offer |
| chan_data | input | 256 | Channel samples; channel i occupies bits 32i+31..32i |
| chan_ack | output | 8 | One-hot acceptance (or drop) of a channel offer |
| core_req | input | 1 | Core access request, held until core_rdy |
| core_we | input | 1 | 1 = write into queue, 0 = read from queue |
| core_wdata | input | 32 | Core write word |
| core_rdata | output | 32 | Read word, valid while core_rdy on a read |
| core_rdy | output | 1 | Access completes this cycle |
| cfg_thresh | input | 4 | Interrupt level |
| cfg_nostall | input | 1 | 1 = never hold accesses |
| cfg_dma_en | input | 1 | DMA select for all channels |
| cfg_enable | input | 1 | Block enable; falling edge flushes |
| cfg_ovf_clr | input | 1 | Write-one pulse clearing ovf_flag |
| irq | output | 1 | Fill level above cfg_thresh |
| ovf_flag | output | 1 | Sticky channel overflow |
| fill_cnt | output | 4 | Stored entry count |
| dma_en | output | 1 | Copy of cfg_dma_en |

## Verification
A wrong pointer shows up on the next completing read as a word out of order. A corrupted count shows up one cycle later on fill_cnt and irq. It can also leave core_rdy stuck low on a stalled access, or high on an access that should have been held.

A missed flush edge or a lost overflow event is visible on the cycle after the event, through fill_cnt or ovf_flag. Arbitration faults appear in the same cycle as a chan_ack with more than one bit set, or with the wrong bit set.

// File: rtl/sif_pkg.sv
package sif_pkg;

    localparam int SIF_DW  = 32;
    localparam int SIF_NCH = 8;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_RD   = 2'd1,
        ACC_WR   = 2'd2
    } acc_e;

    typedef struct packed {
        logic              vld;
        logic [SIF_DW-1:0] data;
    } word_t;

    // Isolate lowest set bit: fixed priority, index 0 first.
    function automatic logic [SIF_NCH-1:0] low_grant(input logic [SIF_NCH-1:0] req);
        return req & (~req + {{(SIF_NCH-1){1'b0}}, 1'b1});
    endfunction

endpackage

// File: rtl/sif_store.sv
module sif_store
    import sif_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  word_t             push,
    input  logic              pop,
    output logic [SIF_DW-1:0] head,
    output logic [CW-1:0]     cnt,
    output logic              full,
    output logic              empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [SIF_DW-1:0] mem [DEPTH];
    logic [AW-1:0]     wp, rp;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push.vld && !flush)
            mem[wp] <= push.data;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push.vld) wp <= nxt(wp);
            if (pop)      rp <= nxt(rp);
            cnt <= cnt + CW'(push.vld) - CW'(pop);
        end
    end

    assign head  = mem[rp];
    assign full  = (cnt == CW'(DEPTH));
    assign empty = (cnt == '0);

    // R2
    fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));
    // R5
    no_push_full_chk: assert property (@(posedge clk) disable iff (rst)
        full |-> !push.vld);
    // R6
    no_pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
        empty |-> !pop);

endmodule

// File: rtl/sif_arb.sv
module sif_arb
    import sif_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic [SIF_NCH-1:0]        chan_req,
    input  logic [SIF_NCH*SIF_DW-1:0] chan_data,
    input  acc_e                      acc,
    input  logic [SIF_DW-1:0]         core_wdata,
    input  logic [SIF_DW-1:0]         head,
    input  logic                      full,
    input  logic                      empty,
    input  logic                      nostall,
    input  logic                      enable,
    input  logic                      flush,
    output logic [SIF_NCH-1:0]        chan_ack,
    output logic                      core_rdy,
    output logic [SIF_DW-1:0]         core_rdata,
    output word_t                     push,
    output logic                      pop,
    output logic                      drop
);
    logic [SIF_NCH-1:0] gnt;
    logic [SIF_DW-1:0]  sel;
    logic               core_push;

    always_comb begin
        gnt = low_grant(chan_req);
        sel = '0;
        for (int i = 0; i < SIF_NCH; i++)
            if (gnt[i]) sel = chan_data[i*SIF_DW +: SIF_DW];
    end

    always_comb begin
        chan_ack   = '0;
        core_rdy   = 1'b0;
        core_rdata = '0;
        push       = '0;
        pop        = 1'b0;
        drop       = 1'b0;
        core_push  = 1'b0;
        if (!flush) begin
            unique case (acc)
                ACC_WR: begin
                    if (!full) begin
                        core_rdy  = 1'b1;
                        push.vld  = 1'b1;
                        push.data = core_wdata;
                        core_push = 1'b1;
                    end else if (nostall) begin
                        core_rdy = 1'b1;
                    end
                end
                ACC_RD: begin
                    if (!empty) begin
                        core_rdy   = 1'b1;
                        pop        = 1'b1;
                        core_rdata = head;
                    end else if (nostall) begin
                        core_rdy = 1'b1;
                    end
                end
                default: ;
            endcase
            if (enable && (|chan_req) && !core_push) begin
                if (!full) begin
                    chan_ack  = gnt;
                    push.vld  = 1'b1;
                    push.data = sel;
                end else if (nostall) begin
                    chan_ack = gnt;
                    drop     = 1'b1;
                end
            end
        end
    end

    // R11
    ack_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(chan_ack));
    // R10
    dis_no_ack_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |-> (chan_ack == '0));
    // R11
    ack_has_req_chk: assert property (@(posedge clk) disable iff (rst)
        ((chan_ack & ~chan_req) == '0));

endmodule

// File: rtl/sif_stat.sv
module sif_stat #(
    parameter int DEPTH = 8,
    parameter int TW    = 4,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enable,
    input  logic          ovf_clr,
    input  logic          drop,
    input  logic [CW-1:0] cnt,
    input  logic [TW-1:0] thresh,
    output logic          flush,
    output logic          ovf,
    output logic          irq
);
    logic en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= 1'b0;
            ovf  <= 1'b0;
        end else begin
            en_q <= enable;
            if (drop)         ovf <= 1'b1;
            else if (ovf_clr) ovf <= 1'b0;
        end
    end

    assign flush = en_q && !enable;
    assign irq   = (32'(cnt) > 32'(thresh));

    // R8
    ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
        drop |=> ovf);
    // R8
    ovf_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf_clr && !drop) |=> !ovf);
    // R9
    flush_empties_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (cnt == '0));

endmodule

// File: rtl/sif_infifo.sv
module sif_infifo
    import sif_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int TW    = 4,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [SIF_NCH-1:0]        chan_req,
    input  logic [SIF_NCH*SIF_DW-1:0] chan_data,
    output logic [SIF_NCH-1:0]        chan_ack,
    input  logic                      core_req,
    input  logic                      core_we,
    input  logic [SIF_DW-1:0]         core_wdata,
    output logic [SIF_DW-1:0]         core_rdata,
    output logic                      core_rdy,
    input  logic [TW-1:0]             cfg_thresh,
    input  logic                      cfg_nostall,
    input  logic                      cfg_dma_en,
    input  logic                      cfg_enable,
    input  logic                      cfg_ovf_clr,
    output logic                      irq,
    output logic                      ovf_flag,
    output logic [CW-1:0]             fill_cnt,
    output logic                      dma_en
);
    acc_e              acc;
    word_t             push;
    logic              pop, drop, flush, full, empty;
    logic [SIF_DW-1:0] head;

    assign acc    = !core_req ? ACC_NONE : (core_we ? ACC_WR : ACC_RD);
    assign dma_en = cfg_dma_en;

    sif_store #(.DEPTH(DEPTH), .CW(CW)) u_store (
        .clk(clk), .rst(rst), .flush(flush), .push(push), .pop(pop),
        .head(head), .cnt(fill_cnt), .full(full), .empty(empty)
    );

    sif_arb u_arb (
        .clk(clk), .rst(rst), .chan_req(chan_req), .chan_data(chan_data),
        .acc(acc), .core_wdata(core_wdata), .head(head), .full(full),
        .empty(empty), .nostall(cfg_nostall), .enable(cfg_enable),
        .flush(flush), .chan_ack(chan_ack), .core_rdy(core_rdy),
        .core_rdata(core_rdata), .push(push), .pop(pop), .drop(drop)
    );

    sif_stat #(.DEPTH(DEPTH), .TW(TW), .CW(CW)) u_stat (
        .clk(clk), .rst(rst), .enable(cfg_enable), .ovf_clr(cfg_ovf_clr),
        .drop(drop), .cnt(fill_cnt), .thresh(cfg_thresh),
        .flush(flush), .ovf(ovf_flag), .irq(irq)
    );

    // R4
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (core_req && !core_we && fill_cnt == '0 && !cfg_nostall) |-> !core_rdy);
    // R5
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (core_req && core_we && fill_cnt == CW'(DEPTH) && !cfg_nostall) |-> !core_rdy);
    // R6
    wr_discard_chk: assert property (@(posedge clk) disable iff (rst)
        (core_req && core_we && fill_cnt == CW'(DEPTH) && cfg_nostall && !flush)
        |=> (fill_cnt == CW'(DEPTH)));
    // R9
    flush_no_rdy_chk: assert property (@(posedge clk) disable iff (rst)
        flush |-> !core_rdy);

endmodule

// File: tb/sim_sif_infifo.sv
module sim_sif_infifo;
    import sif_pkg::*;

    localparam int NCH = SIF_NCH;
    localparam int DW  = SIF_DW;
    localparam int NV  = 10;

    typedef struct packed {
        logic [1:0]  op;    // 0 channel offer, 1 core write, 2 core read
        logic [2:0]  ch;
        logic [31:0] dat;   // offered/written word, or expected read word
        logic        resp;  // expected ack/ready
        logic [3:0]  cnt;   // expected fill after the edge
        logic        irq;   // expected irq after the edge (level 2)
    } vec_t;

    localparam vec_t VEC [NV] = '{
        '{2'd0, 3'd3, 32'h0000_00A3, 1'b1, 4'd1, 1'b0},
        '{2'd1, 3'd0, 32'h0000_0011, 1'b1, 4'd2, 1'b0},
        '{2'd0, 3'd0, 32'h0000_0020, 1'b1, 4'd3, 1'b1},
        '{2'd2, 3'd0, 32'h0000_00A3, 1'b1, 4'd2, 1'b0},
        '{2'd2, 3'd0, 32'h0000_0011, 1'b1, 4'd1, 1'b0},
        '{2'd0, 3'd7, 32'h0000_0077, 1'b1, 4'd2, 1'b0},
        '{2'd2, 3'd0, 32'h0000_0020, 1'b1, 4'd1, 1'b0},
        '{2'd2, 3'd0, 32'h0000_0077, 1'b1, 4'd0, 1'b0},
        '{2'd1, 3'd0, 32'h0000_0055, 1'b1, 4'd1, 1'b0},
        '{2'd2, 3'd0, 32'h0000_0055, 1'b1, 4'd0, 1'b0}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NCH-1:0]    chan_req = '0;
    logic [NCH*DW-1:0] chan_data = '0;
    logic [NCH-1:0]    chan_ack;
    logic              core_req = 1'b0, core_we = 1'b0;
    logic [DW-1:0]     core_wdata = '0, core_rdata;
    logic              core_rdy;
    logic [3:0]        cfg_thresh = 4'd2;
    logic              cfg_nostall = 1'b0, cfg_dma_en = 1'b0;
    logic              cfg_enable = 1'b1, cfg_ovf_clr = 1'b0;
    logic              irq, ovf_flag, dma_en;
    logic [3:0]        fill_cnt;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    sif_infifo u0 (
        .clk(clk), .rst(rst), .chan_req(chan_req), .chan_data(chan_data),
        .chan_ack(chan_ack), .core_req(core_req), .core_we(core_we),
        .core_wdata(core_wdata), .core_rdata(core_rdata), .core_rdy(core_rdy),
        .cfg_thresh(cfg_thresh), .cfg_nostall(cfg_nostall),
        .cfg_dma_en(cfg_dma_en), .cfg_enable(cfg_enable),
        .cfg_ovf_clr(cfg_ovf_clr), .irq(irq), .ovf_flag(ovf_flag),
        .fill_cnt(fill_cnt), .dma_en(dma_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic rd_expect(input string req, input logic [31:0] exp);
        core_req = 1'b1; core_we = 1'b0;
        #1;
        chk(req, {31'd0, core_rdy}, 32'd1);
        chk(req, core_rdata, exp);
        tick();
        core_req = 1'b0;
    endtask

    task automatic wr_word(input logic [31:0] w);
        core_req = 1'b1; core_we = 1'b1; core_wdata = w;
        tick();
        core_req = 1'b0; core_we = 1'b0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        chk("R1 fill", 32'(fill_cnt), 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 ovf", 32'(ovf_flag), 0);
        chk("R1 rdy", 32'(core_rdy), 0);
        chk("R1 ack", 32'(chan_ack), 0);

        // Table walk: R2 ordering and counting, R3 level, R11 indexed acks
        for (int i = 0; i < NV; i++) begin
            case (VEC[i].op)
                2'd0: begin
                    chan_data[VEC[i].ch*DW +: DW] = VEC[i].dat;
                    chan_req[VEC[i].ch] = 1'b1;
                end
                2'd1: begin core_req = 1'b1; core_we = 1'b1; core_wdata = VEC[i].dat; end
                default: begin core_req = 1'b1; core_we = 1'b0; end
            endcase
            #1;
            if (VEC[i].op == 2'd0)
                chk("R11 table ack", 32'(chan_ack[VEC[i].ch]), 32'(VEC[i].resp));
            else
                chk("R2 table rdy", 32'(core_rdy), 32'(VEC[i].resp));
            if (VEC[i].op == 2'd2)
                chk("R2 table rdata", core_rdata, VEC[i].dat);
            tick();
            chan_req = '0; core_req = 1'b0; core_we = 1'b0;
            chk("R2 table fill", 32'(fill_cnt), 32'(VEC[i].cnt));
            chk("R3 table irq", 32'(irq), 32'(VEC[i].irq));
        end

        for (int c = 0; c < NCH; c++) chan_data[c*DW +: DW] = 32'hC000_0000 | c;

        // R4 stalled read of empty queue
        core_req = 1'b1; core_we = 1'b0;
        #1; chk("R4 hold0", 32'(core_rdy), 0);
        tick();
        #1; chk("R4 hold1", 32'(core_rdy), 0);
        tick();
        chan_req = 8'h20;
        #1; chk("R4 hold2", 32'(core_rdy), 0);
        chk("R11 ack5", 32'(chan_ack), 32'h20);
        tick();
        chan_req = '0;
        #1; chk("R4 release", 32'(core_rdy), 1);
        chk("R4 data", core_rdata, 32'hC000_0005);
        tick();
        core_req = 1'b0;
        chk("R4 fill", 32'(fill_cnt), 0);

        // Fill to capacity, R3 boundaries
        for (int k = 0; k < 8; k++) wr_word(32'h100 + k);
        chk("R2 full", 32'(fill_cnt), 8);
        chk("R3 lvl2", 32'(irq), 1);
        cfg_thresh = 4'd8; #1; chk("R3 lvl8", 32'(irq), 0);
        cfg_thresh = 4'd7; #1; chk("R3 lvl7", 32'(irq), 1);
        cfg_thresh = 4'd2;
        tick();

        // R5 stalled write to full queue
        core_req = 1'b1; core_we = 1'b1; core_wdata = 32'hDEAD;
        #1; chk("R5 hold0", 32'(core_rdy), 0);
        tick();
        #1; chk("R5 hold1", 32'(core_rdy), 0);
        tick();
        core_req = 1'b0; core_we = 1'b0;
        chk("R5 fill", 32'(fill_cnt), 8);
        // R7 channel held when full and stalling
        chan_req = 8'h02;
        #1; chk("R7 held ack", 32'(chan_ack), 0);
        tick();
        chan_req = '0;
        chk("R7 held fill", 32'(fill_cnt), 8);
        chk("R7 held ovf", 32'(ovf_flag), 0);

        // R5 write completes once a slot frees
        rd_expect("R2 first", 32'h100);
        core_req = 1'b1; core_we = 1'b1; core_wdata = 32'hBEEF;
        #1; chk("R5 done", 32'(core_rdy), 1);
        tick();
        core_req = 1'b0; core_we = 1'b0;
        chk("R5 fill8", 32'(fill_cnt), 8);

        // R6 non-stalling write to full queue
        cfg_nostall = 1'b1;
        core_req = 1'b1; core_we = 1'b1; core_wdata = 32'hBAD;
        #1; chk("R6 wr rdy", 32'(core_rdy), 1);
        tick();
        core_req = 1'b0; core_we = 1'b0;
        chk("R6 wr discard", 32'(fill_cnt), 8);

        // R7 channel drop and sticky overflow
        chan_req = 8'h04;
        #1; chk("R7 drop ack", 32'(chan_ack), 32'h04);
        tick();
        chan_req = '0;
        chk("R7 ovf", 32'(ovf_flag), 1);
        chk("R7 fill", 32'(fill_cnt), 8);
        tick(); tick();
        chk("R7 sticky", 32'(ovf_flag), 1);

        // R8 clear, then set-beats-clear
        cfg_ovf_clr = 1'b1;
        tick();
        cfg_ovf_clr = 1'b0;
        chk("R8 cleared", 32'(ovf_flag), 0);
        cfg_ovf_clr = 1'b1; chan_req = 8'h01;
        tick();
        cfg_ovf_clr = 1'b0; chan_req = '0;
        chk("R8 set wins", 32'(ovf_flag), 1);
        cfg_ovf_clr = 1'b1;
        tick();
        cfg_ovf_clr = 1'b0;
        chk("R8 clear2", 32'(ovf_flag), 0);

        // R2 drain order
        for (int k = 1; k < 8; k++) rd_expect("R2 order", 32'h100 + k);
        rd_expect("R2 order last", 32'hBEEF);
        chk("R2 drained", 32'(fill_cnt), 0);

        // R6 non-stalling read of empty queue
        core_req = 1'b1; core_we = 1'b0;
        #1; chk("R6 rd rdy", 32'(core_rdy), 1);
        chk("R6 rd zero", core_rdata, 0);
        tick();
        core_req = 1'b0;
        chk("R6 rd fill", 32'(fill_cnt), 0);
        cfg_nostall = 1'b0;

        // R11 arbitration
        core_req = 1'b1; core_we = 1'b1; core_wdata = 32'hAA; chan_req = 8'hA4;
        #1; chk("R11 core first", 32'(core_rdy), 1);
        chk("R11 core blocks", 32'(chan_ack), 0);
        tick();
        core_req = 1'b0; core_we = 1'b0;
        #1; chk("R11 low2", 32'(chan_ack), 32'h04);
        tick();
        chan_req = 8'hA0;
        #1; chk("R11 low5", 32'(chan_ack), 32'h20);
        tick();
        chan_req = 8'h80;
        #1; chk("R11 low7", 32'(chan_ack), 32'h80);
        tick();
        chan_req = '0;
        chk("R11 fill", 32'(fill_cnt), 4);
        rd_expect("R11 o0", 32'hAA);
        rd_expect("R11 o1", 32'hC000_0002);
        rd_expect("R11 o2", 32'hC000_0005);
        rd_expect("R11 o3", 32'hC000_0007);

        // R10 disabled refuses channel data
        cfg_enable = 1'b0;
        tick();
        chan_req = 8'h01;
        #1; chk("R10 ack", 32'(chan_ack), 0);
        tick();
        chan_req = '0;
        chk("R10 fill", 32'(fill_cnt), 0);
        cfg_enable = 1'b1;
        tick();

        // R9 flush on falling enable
        for (int k = 0; k < 3; k++) wr_word(32'h300 + k);
        chk("R9 pre", 32'(fill_cnt), 3);
        cfg_enable = 1'b0; core_req = 1'b1; core_we = 1'b0;
        #1; chk("R9 no rdy", 32'(core_rdy), 0);
        tick();
        core_req = 1'b0;
        chk("R9 flushed", 32'(fill_cnt), 0);
        cfg_enable = 1'b1;
        tick();

        // R12 DMA select pass-through
        cfg_dma_en = 1'b1; #1; chk("R12 on", 32'(dma_en), 1);
        cfg_dma_en = 1'b0; #1; chk("R12 off", 32'(dma_en), 0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule